// File: doc/BRIEF.md
# Processor Status and Control Register

This block is the byte-wide status and control word of a small microcontroller core. It records which event caused the most recent restart: a power-up, a watchdog expiry, or a reset signalled on the upstream USB port. It holds the core's run flag and a suspend request. It also shows the live interrupt-enable state and a flag for recognised but unserviced interrupts. The core reads the word and writes it through a simple strobe-and-data port. The block drives a run/halt line and a suspend line back to the core.

Each reset source touches a different set of bits. A power-up loads a fixed pattern. A watchdog expiry restarts the core but keeps the power-up and bus-reset flags, so firmware can tell the two causes apart. A halt strobe clears the whole word, and only a power-up or watchdog restart brings the core back. A suspend request is refused while the bus is active. An accepted suspend lasts until bus activity or an enabled interrupt request wakes the core.

Bit layout (bit 7 to bit 0): pending, watchdog cause, bus-reset cause, power-up cause, suspend, interrupt-enable sense, reserved, run.

Top module: `cpu_status_ctl`

## Requirements
- R1: While the asynchronous power-up reset `rst_n` is low, and after it is released, the register reads 8'h11 with bit 2 mirroring `ie_state`. In this state `run_o` is 1 and `suspend_o` is 0.
- R2: A `wdt_rst` strobe sets bit 6 and the run bit, and clears bit 7 and the suspend bit (bit 3), one clock later. Bits 4 and 5 keep their values.
- R3: A `halt_exec` strobe clears every stored bit one clock later, so `run_o` goes low. Run then stays 0, whatever is written to bit 0, until a watchdog or power-up reset. Writes to bit 0 never change it.
- R4: Bit 2 always equals the `ie_state` input. Writes to bit 2 have no effect.
- R5: Bit 1 always reads 0.
- R6: A write with bit 3 = 1 sets the suspend bit one clock later, but only while run is 1 and `bus_active` is 0. While the suspend bit is set, `suspend_o` is 1 and `run_o` is 0.
- R7: A suspend write made while `bus_active` is 1 is ignored.
- R8: While suspended, `bus_active` = 1 or any bit of `irq_req & irq_en` clears the suspend bit one clock later. A pending request whose enable is 0 does not wake the core.
- R9: Bit 7 sets one clock after any `irq_req` bit is 1, and clears one clock after `irq_ack`. Writes do not affect bit 7.
- R10: A `usb_bus_rst` strobe sets bit 5 one clock later.
- R11: Writing 0 to bit 4, 5 or 6 clears that bit. Writing 1 to it leaves it unchanged.
- R12: When a hardware set event (bus reset, watchdog, interrupt request) and a clear (firmware write, halt, acknowledge) reach the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| wdt_rst | input | 1 | Watchdog expiry strobe |
| usb_bus_rst | input | 1 | Upstream bus reset detected strobe |
| halt_exec | input | 1 | Halt instruction executed strobe |
| ie_state | input | 1 | Global interrupt-enable state from the core |
| bus_active | input | 1 | Upstream bus activity present |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| irq_ack | input | 1 | Interrupt serviced strobe |
| rd_data | output | 8 | Current register value |
| run_o | output | 1 | Core may execute (run set, not suspended) |
| suspend_o | output | 1 | Suspend mode active |

## Verification
Several reset sequences are applied, each on top of a different set of cause flags. Power-up alone, watchdog after a bus reset, and halt together with a bus reset show which bits each source keeps and which it clears. The suspend path is exercised against bus activity, a disabled request and an enabled request, which separates a refused entry, a held suspend and a wake. Same-cycle collisions of set events with writes, acknowledges and halts pin down the priority. A long run of pseudo-random strobes and writes, compared each clock with a reference model, exposes interactions that the directed cases miss.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
   localparam int REG_W      = 8;
   localparam int BIT_RUN    = 0;
   localparam int BIT_RSVD   = 1;
   localparam int BIT_IESNS  = 2;
   localparam int BIT_SUSP   = 3;
   localparam int BIT_POR    = 4;
   localparam int BIT_BUSRST = 5;
   localparam int BIT_WDR    = 6;
   localparam int BIT_PEND   = 7;

   localparam int CAUSE_N    = 3;
   localparam int CAUSE_POR  = 0;
   localparam int CAUSE_BUS  = 1;
   localparam int CAUSE_WDR  = 2;

   typedef struct packed {
      logic pend;
      logic wdr;
      logic busrst;
      logic por;
      logic susp;
      logic ie;
      logic rsvd;
      logic run;
   } stat_word_t;
endpackage

// File: rtl/cpu_status_cause.sv
module cpu_status_cause
   import cpu_status_pkg::*;
#(
   parameter int             N       = CAUSE_N,
   parameter logic [N-1:0]   RST_VAL = 3'b001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wdt_hit,
   input  logic         clr_all,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] set_ev,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("cpu_status_cause: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_r;
      logic clr_i;

      // a watchdog restart suppresses every clear path
      assign clr_i = ~wdt_hit & (clr_all | (wr_en & ~wr_bits[i]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_r <= RST_VAL[i];
         else        flag_r <= set_ev[i] | (flag_r & ~clr_i);
      end

      assign q[i] = flag_r;

      AST_CAUSE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[i] |=> q[i]);                                             // R12
      AST_CAUSE_WDT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (wdt_hit && q[i]) |=> q[i]);                                     // R2
      AST_CAUSE_NO_WR_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_ev[i] && !q[i]) |=> !q[i]);                                // R11
      AST_CAUSE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_bits[i] && !set_ev[i] && !wdt_hit) |=> !q[i]);     // R11
   end
endmodule

// File: rtl/cpu_status_exec.sv
module cpu_status_exec #(
   parameter bit WAKE_ON_BUS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_hit,
   input  logic halt,
   input  logic wr_susp,
   input  logic bus_active,
   input  logic wake_irq,
   output logic run_q,
   output logic susp_q,
   output logic run_o
);
   logic run_r;
   logic susp_r;
   logic wake;
   logic enter;

   if (WAKE_ON_BUS) begin : g_wake_bus
      assign wake = bus_active | wake_irq;
   end else begin : g_wake_irq
      assign wake = wake_irq;
   end

   assign enter = wr_susp & ~bus_active & run_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_r  <= 1'b1;
         susp_r <= 1'b0;
      end else if (wdt_hit) begin
         run_r  <= 1'b1;
         susp_r <= 1'b0;
      end else if (halt) begin
         run_r  <= 1'b0;
         susp_r <= 1'b0;
      end else if (susp_r) begin
         susp_r <= ~wake;
      end else begin
         susp_r <= enter;
      end
   end

   assign run_q  = run_r;
   assign susp_q = susp_r;
   assign run_o  = run_r & ~susp_r;

   AST_WDT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_hit |=> (run_q && !susp_q));                                    // R2
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wdt_hit) |=> !run_q);                                   // R3
   AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!susp_q && run_q && wr_susp && !bus_active && !wdt_hit && !halt) |=> susp_q); // R6
   AST_SUSP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!susp_q && wr_susp && bus_active) |=> !susp_q);                    // R7
   AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_q && wake) |=> !susp_q);                                      // R8
endmodule

// File: rtl/cpu_status_irq.sv
module cpu_status_irq #(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wdt_hit,
   input  logic               halt,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               irq_ack,
   output logic               pend_q,
   output logic               wake_irq
);
   logic any_req;
   logic pend_r;

   if (NUM_IRQ < 1) begin : g_bad_n
      $error("cpu_status_irq: NUM_IRQ must be at least 1");
   end

   if (NUM_IRQ == 1) begin : g_single
      assign any_req  = irq_req[0];
      assign wake_irq = irq_req[0] & irq_en[0];
   end else begin : g_multi
      assign any_req  = |irq_req;
      assign wake_irq = |(irq_req & irq_en);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_r <= 1'b0;
      else if (wdt_hit) pend_r <= 1'b0;
      else              pend_r <= any_req | (pend_r & ~(irq_ack | halt));
   end

   assign pend_q = pend_r;

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req && !wdt_hit) |=> pend_q);                                 // R9
   AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && irq_ack && !(|irq_req)) |=> !pend_q);                    // R9
   AST_PEND_WDT: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_hit |=> !pend_q);                                               // R2
endmodule

// File: rtl/cpu_status_ctl.sv
module cpu_status_ctl
   import cpu_status_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_IRQ     = 4,
   parameter bit WAKE_ON_BUS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               wdt_rst,
   input  logic               usb_bus_rst,
   input  logic               halt_exec,
   input  logic               ie_state,
   input  logic               bus_active,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               irq_ack,
   output logic [DATA_W-1:0]  rd_data,
   output logic               run_o,
   output logic               suspend_o
);
   if (DATA_W != REG_W) begin : g_bad_w
      $error("cpu_status_ctl: DATA_W must equal the register width");
   end

   logic [CAUSE_N-1:0] cause_q;
   logic [CAUSE_N-1:0] cause_set;
   logic [CAUSE_N-1:0] cause_wr;
   logic               run_q;
   logic               susp_q;
   logic               pend_q;
   logic               wake_irq;
   logic               wr_susp;
   stat_word_t         word;
   logic               unused_wr;

   assign cause_set[CAUSE_POR] = 1'b0;
   assign cause_set[CAUSE_BUS] = usb_bus_rst;
   assign cause_set[CAUSE_WDR] = wdt_rst;

   assign cause_wr[CAUSE_POR]  = wr_data[BIT_POR];
   assign cause_wr[CAUSE_BUS]  = wr_data[BIT_BUSRST];
   assign cause_wr[CAUSE_WDR]  = wr_data[BIT_WDR];

   assign wr_susp   = wr_en & wr_data[BIT_SUSP];
   assign unused_wr = ^{wr_data[BIT_PEND], wr_data[BIT_IESNS],
                        wr_data[BIT_RSVD], wr_data[BIT_RUN]};

   cpu_status_cause #(
      .N       (CAUSE_N),
      .RST_VAL (3'b001)
   ) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdt_hit (wdt_rst),
      .clr_all (halt_exec),
      .wr_en   (wr_en),
      .wr_bits (cause_wr),
      .set_ev  (cause_set),
      .q       (cause_q)
   );

   cpu_status_exec #(
      .WAKE_ON_BUS (WAKE_ON_BUS)
   ) u_exec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdt_hit    (wdt_rst),
      .halt       (halt_exec),
      .wr_susp    (wr_susp),
      .bus_active (bus_active),
      .wake_irq   (wake_irq),
      .run_q      (run_q),
      .susp_q     (susp_q),
      .run_o      (run_o)
   );

   cpu_status_irq #(
      .NUM_IRQ (NUM_IRQ)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdt_hit  (wdt_rst),
      .halt     (halt_exec),
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_ack  (irq_ack),
      .pend_q   (pend_q),
      .wake_irq (wake_irq)
   );

   always_comb begin
      word        = '0;
      word.pend   = pend_q;
      word.wdr    = cause_q[CAUSE_WDR];
      word.busrst = cause_q[CAUSE_BUS];
      word.por    = cause_q[CAUSE_POR];
      word.susp   = susp_q;
      word.ie     = ie_state;
      word.rsvd   = 1'b0;
      word.run    = run_q;
   end

   assign rd_data   = word;
   assign suspend_o = susp_q;

   AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_exec && !wdt_rst && !usb_bus_rst && !(|irq_req))
         |=> (rd_data[7:3] == 5'b0 && rd_data[BIT_RUN] == 1'b0));         // R3
   AST_BUSRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
      usb_bus_rst |=> rd_data[BIT_BUSRST]);                               // R10
   AST_SUSP_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend_o && !bus_active && !wake_irq && !wdt_rst && !halt_exec) |=> !run_o); // R6
endmodule

// File: tb/cpu_status_ctl_bench.sv
module cpu_status_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NIRQ       = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [7:0]      wr_data = '0;
   logic            wdt_rst = 1'b0;
   logic            usb_bus_rst = 1'b0;
   logic            halt_exec = 1'b0;
   logic            ie_state = 1'b0;
   logic            bus_active = 1'b0;
   logic [NIRQ-1:0] irq_req = '0;
   logic [NIRQ-1:0] irq_en = '0;
   logic            irq_ack = 1'b0;
   logic [7:0]      rd_data;
   logic            run_o;
   logic            suspend_o;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_run, m_susp, m_por, m_bus, m_wdr, m_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_status_ctl #(.DATA_W(8), .NUM_IRQ(NIRQ)) u_cpu_status_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wdt_rst(wdt_rst), .usb_bus_rst(usb_bus_rst), .halt_exec(halt_exec),
      .ie_state(ie_state), .bus_active(bus_active), .irq_req(irq_req),
      .irq_en(irq_en), .irq_ack(irq_ack), .rd_data(rd_data),
      .run_o(run_o), .suspend_o(suspend_o)
   );

   function automatic logic [7:0] model_word();
      return {m_pend, m_wdr, m_bus, m_por, m_susp, ie_state, 1'b0, m_run};
   endfunction

   task automatic model_reset();
      m_run = 1; m_susp = 0; m_por = 1; m_bus = 0; m_wdr = 0; m_pend = 0;
   endtask

   task automatic model_clock();
      bit any_req, wake;
      any_req = (irq_req != 0);
      wake    = bus_active || ((irq_req & irq_en) != 0);
      if (wdt_rst) begin
         m_run = 1; m_susp = 0; m_wdr = 1; m_pend = 0;
         if (usb_bus_rst) m_bus = 1;
      end else begin
         if (halt_exec || (wr_en && !wr_data[4])) m_por = 0;
         if (halt_exec || (wr_en && !wr_data[5])) m_bus = 0;
         if (halt_exec || (wr_en && !wr_data[6])) m_wdr = 0;
         if (usb_bus_rst) m_bus = 1;
         if (halt_exec || irq_ack) m_pend = 0;
         if (any_req) m_pend = 1;
         if (halt_exec) begin
            m_run = 0; m_susp = 0;
         end else if (m_susp) begin
            if (wake) m_susp = 0;
         end else if (wr_en && wr_data[3] && !bus_active && m_run) begin
            m_susp = 1;
         end
      end
   endtask

   function automatic string bit_tag(int b);
      case (b)
         0: return "R3";  1: return "R5";  2: return "R4";  3: return "R6";
         4: return "R11"; 5: return "R10"; 6: return "R2";  default: return "R9";
      endcase
   endfunction

   task automatic compare_all();
      logic [7:0] exp;
      exp = model_word();
      checks++;
      if (rd_data !== exp) begin
         fails++;
         for (int b = 0; b < 8; b++)
            if (rd_data[b] !== exp[b])
               $display("FAIL %s model bit %0d: rd_data=%h expected %h", bit_tag(b), b, rd_data, exp);
      end
      checks++;
      if (run_o !== (m_run && !m_susp)) begin
         fails++;
         $display("FAIL R3 model run_o=%b expected %b", run_o, m_run && !m_susp);
      end
      checks++;
      if (suspend_o !== m_susp) begin
         fails++;
         $display("FAIL R6 model suspend_o=%b expected %b", suspend_o, m_susp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_clock();
      @(negedge clk);
      compare_all();
   endtask

   task automatic chk(string tag, logic [7:0] exp);
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s rd_data=%h expected %h", tag, rd_data, exp);
      end
   endtask

   task automatic chk_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s=%b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic write(logic [7:0] d);
      wr_en = 1; wr_data = d;
      step();
      wr_en = 0; wr_data = '0;
   endtask

   task automatic power_up();
      rst_n = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      compare_all();
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      fails++;
      $display("FAIL watchdog expired, no requirement reached");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      power_up();
      chk("R1", 8'h11);
      chk_bit("R1", "run_o", run_o, 1'b1);
      chk_bit("R1", "suspend_o", suspend_o, 1'b0);

      ie_state = 1; step();
      chk("R4", 8'h15);

      write(8'h00);                       // clears bit 4, bit 0 unaffected
      chk("R11", 8'h05);
      chk_bit("R3", "run_o", run_o, 1'b1);

      bus_active = 1;
      write(8'hFE);                       // suspend refused, no bit settable
      chk("R7", 8'h05);
      chk_bit("R5", "rd_data[1]", rd_data[1], 1'b0);
      bus_active = 0;

      usb_bus_rst = 1; step(); usb_bus_rst = 0;
      chk("R10", 8'h25);
      usb_bus_rst = 1; write(8'h00); usb_bus_rst = 0;
      chk("R12", 8'h25);
      write(8'h00);
      chk("R11", 8'h05);

      irq_req = 4'b0010; step();
      chk("R9", 8'h85);
      irq_ack = 1; step();
      chk("R12", 8'h85);
      irq_req = '0; step(); irq_ack = 0;
      chk("R9", 8'h05);

      write(8'h08);
      chk("R6", 8'h0D);
      chk_bit("R6", "run_o", run_o, 1'b0);
      chk_bit("R6", "suspend_o", suspend_o, 1'b1);
      step();
      chk("R6", 8'h0D);
      irq_req = 4'b0100; step();
      chk("R8", 8'h8D);
      irq_en = 4'b0100; step();
      chk("R8", 8'h85);
      chk_bit("R8", "run_o", run_o, 1'b1);
      irq_req = '0; irq_en = '0; irq_ack = 1; step(); irq_ack = 0;

      write(8'h08);
      chk("R6", 8'h0D);
      bus_active = 1; step(); bus_active = 0;
      chk("R8", 8'h05);

      usb_bus_rst = 1; step(); usb_bus_rst = 0;
      irq_req = 4'b0001; step(); irq_req = '0;
      chk("R9", 8'hA5);
      wdt_rst = 1; step(); wdt_rst = 0;
      chk("R2", 8'h65);

      halt_exec = 1; step(); halt_exec = 0;
      chk("R3", 8'h04);
      chk_bit("R3", "run_o", run_o, 1'b0);
      write(8'h01);
      chk("R3", 8'h04);
      write(8'h08);
      chk("R6", 8'h04);
      chk_bit("R6", "suspend_o", suspend_o, 1'b0);
      wdt_rst = 1; step(); wdt_rst = 0;
      chk("R2", 8'h45);
      chk_bit("R2", "run_o", run_o, 1'b1);

      write(8'h48);
      chk("R6", 8'h4D);
      wdt_rst = 1; step(); wdt_rst = 0;
      chk("R2", 8'h45);

      halt_exec = 1; usb_bus_rst = 1; step(); halt_exec = 0; usb_bus_rst = 0;
      chk("R12", 8'h24);
      wdt_rst = 1; step(); wdt_rst = 0;
      chk("R2", 8'h65);

      power_up();
      chk("R1", 8'h15);

      for (int n = 0; n < 2000; n++) begin
         bit [31:0] r;
         r = $urandom;
         wr_en       = r[0] & r[1];
         wr_data     = r[15:8];
         usb_bus_rst = (r[19:16] == 4'd3);
         wdt_rst     = (r[23:19] == 5'd7);
         halt_exec   = (r[28:24] == 5'd9);
         bus_active  = r[2] & r[3];
         irq_req     = (r[6:4] == 3'd0) ? 4'(r[31:28]) : '0;
         irq_en      = 4'(r[30:27]);
         irq_ack     = r[7];
         ie_state    = r[29];
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule